// File: doc/BRIEF.md
# Serial Link to Handshake Port Adaptor

This block joins a bit-serial, full-duplex link to two independent byte-wide ports on a local peripheral. One port takes bytes in and the other gives bytes out, and each port uses a two-wire, four-phase handshake. The block contains its own link transmitter and receiver. A byte offered on the input port goes out as a data frame. A data frame that arrives is presented on the output port.

Each handshake runs end to end across the link. The local device's input acknowledge is withheld until the far end has returned a link acknowledge for that byte. The link acknowledge for a received byte is withheld until the local device has finished reading the output byte. As a result, neither side can run ahead by more than one byte.

The link bit time is chosen by a static speed input: `BIT_SLOW` or `BIT_FAST` clock cycles per bit. The speed may only be changed while the link is idle, and a reset must follow the change.

Top module: `link_port_adaptor`

## Requirements
- R1: While reset is asserted, and on the cycle after it, `in_ack`, `out_valid` and `link_out` are low. The value of `out_data` after reset is not defined.
- R2: A data frame on `link_out` is 11 bits, each held for one bit time. It is sent in this order: 1, 1, data bit 0 up to data bit 7, then 0. The line stays low between frames. An acknowledge frame is 2 bits: 1 then 0.
- R3: `in_ack` rises only after an acknowledge frame has been received on `link_in` for the byte being sent. It stays low for as long as no such frame arrives.
- R4: After `in_valid` falls, `in_ack` falls on the next clock edge. A new byte is taken only on a fresh rising edge of `in_valid` after both signals are low.
- R5: The byte is captured from `in_data` on the clock edge that first sees `in_valid` high. Changes on `in_data` after that edge have no effect on the byte sent.
- R6: A data frame received on `link_in` drives its byte on `out_data` and raises `out_valid`. `out_data` holds steady while `out_valid` is high.
- R7: `out_valid` falls after `out_ack` is seen high. The acknowledge frame for that byte is sent on `link_out` only after `out_ack` has gone low again.
- R8: The bit time is `BIT_FAST` cycles when `speed_fast` is 1 and `BIT_SLOW` cycles when it is 0. With the defaults these are 4 and 8 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| speed_fast | input | 1 | Static link speed select (1 = fast) |
| in_data | input | 8 | Byte from the local device |
| in_valid | input | 1 | Local device offers a byte |
| in_ack | output | 1 | Far end has accepted the byte |
| out_data | output | 8 | Byte received from the link |
| out_valid | output | 1 | `out_data` holds a new byte |
| out_ack | input | 1 | Local device has read `out_data` |
| link_in | input | 1 | Serial link input |
| link_out | output | 1 | Serial link output |

## Verification
A receiver that drifts within a bit, or that reads the frame type wrongly, shows up within one frame as a wrong byte on `out_data` or as an `in_ack` that never rises. A transmitter whose bit counter or reload value is wrong gives wrong bit-centre samples on `link_out`, so the speed setting itself is exposed. A handshake state machine that skips a wait shows up within a few cycles: an early `in_ack`, or an acknowledge frame on `link_out` while `out_ack` is still high. In loopback, every one of the 256 byte values passes through both directions.

// File: rtl/lpa_pkg.sv
package lpa_pkg;
  localparam int DATA_BITS  = 11;
  localparam int ACK_BITS   = 2;
  localparam logic [10:0] ACK_FRAME = 11'b00000000001;

  typedef enum logic [1:0] {IN_IDLE, IN_SEND, IN_WAIT, IN_HOLD} in_state_e;
  typedef enum logic [1:0] {OUT_IDLE, OUT_SHOW, OUT_DRAIN, OUT_ACK} out_state_e;
  typedef enum logic [1:0] {RX_IDLE, RX_TYPE, RX_DATA, RX_STOP} rx_state_e;

  // LSB leaves first: start, data-type flag, eight data bits, stop.
  function automatic logic [10:0] data_frame(input logic [7:0] b);
    return {1'b0, b, 2'b11};
  endfunction

  // Cycles from start detection to the centre of the type bit.
  function automatic int unsigned first_wait(input int unsigned period);
    return period + period / 2;
  endfunction
endpackage

// File: rtl/link_tx.sv
module link_tx #(
  parameter int BIT_SLOW = 8,
  parameter int BIT_FAST = 4,
  localparam int CW = $clog2(BIT_SLOW * 2)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       speed_fast,
  input  logic       data_req,
  input  logic [7:0] data_byte,
  input  logic       ack_req,
  output logic       data_done,
  output logic       ack_done,
  output logic       ack_start,
  output logic       line
);
  import lpa_pkg::*;
  localparam logic [CW-1:0] RELOAD_SLOW = CW'(BIT_SLOW - 1);
  localparam logic [CW-1:0] RELOAD_FAST = CW'(BIT_FAST - 1);

  logic          busy, is_ack, fin;
  logic [10:0]   shreg;
  logic [3:0]    left;
  logic [CW-1:0] cnt, reload;
  logic          can_start;

  assign reload    = speed_fast ? RELOAD_FAST : RELOAD_SLOW;
  assign can_start = !busy && !fin;
  assign ack_start = can_start && ack_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; is_ack <= 1'b0; fin <= 1'b0;
      shreg <= '0; left <= '0; cnt <= '0; line <= 1'b0;
      data_done <= 1'b0; ack_done <= 1'b0;
    end else begin
      fin <= 1'b0; data_done <= 1'b0; ack_done <= 1'b0;
      if (can_start && (ack_req || data_req)) begin
        logic [10:0] fr;
        fr      = ack_req ? ACK_FRAME : data_frame(data_byte);
        is_ack  <= ack_req;
        busy    <= 1'b1;
        line    <= fr[0];
        shreg   <= fr >> 1;
        left    <= ack_req ? 4'(ACK_BITS - 1) : 4'(DATA_BITS - 1);
        cnt     <= reload;
      end else if (busy) begin
        if (cnt != '0) begin
          cnt <= cnt - 1'b1;
        end else if (left != '0) begin
          line  <= shreg[0];
          shreg <= shreg >> 1;
          left  <= left - 1'b1;
          cnt   <= reload;
        end else begin
          busy      <= 1'b0;
          line      <= 1'b0;
          fin       <= 1'b1;
          data_done <= !is_ack;
          ack_done  <= is_ack;
        end
      end
    end
  end
endmodule

// File: rtl/link_rx.sv
module link_rx #(
  parameter int BIT_SLOW = 8,
  parameter int BIT_FAST = 4,
  localparam int CW = $clog2(BIT_SLOW * 2)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       speed_fast,
  input  logic       line,
  output logic       ack_evt,
  output logic       data_evt,
  output logic [7:0] data_byte
);
  import lpa_pkg::*;
  localparam logic [CW-1:0] RELOAD_SLOW = CW'(BIT_SLOW - 1);
  localparam logic [CW-1:0] RELOAD_FAST = CW'(BIT_FAST - 1);
  localparam logic [CW-1:0] FIRST_SLOW  = CW'(first_wait(BIT_SLOW));
  localparam logic [CW-1:0] FIRST_FAST  = CW'(first_wait(BIT_FAST));

  logic [1:0]    sync;
  logic          bit_in;
  rx_state_e     st;
  logic [CW-1:0] cnt;
  logic [2:0]    idx;
  logic [7:0]    shreg;

  assign bit_in = sync[1];

  always_ff @(posedge clk) begin
    if (rst) sync <= 2'b00;
    else     sync <= {sync[0], line};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= RX_IDLE; cnt <= '0; idx <= '0; shreg <= '0;
      ack_evt <= 1'b0; data_evt <= 1'b0; data_byte <= '0;
    end else begin
      ack_evt <= 1'b0; data_evt <= 1'b0;
      case (st)
        RX_IDLE: if (bit_in) begin
          cnt <= speed_fast ? FIRST_FAST : FIRST_SLOW;
          st  <= RX_TYPE;
        end
        RX_TYPE: if (cnt != '0) cnt <= cnt - 1'b1;
          else if (bit_in) begin
            st <= RX_DATA; idx <= '0;
            cnt <= speed_fast ? RELOAD_FAST : RELOAD_SLOW;
          end else begin
            ack_evt <= 1'b1; st <= RX_IDLE;
          end
        RX_DATA: if (cnt != '0) cnt <= cnt - 1'b1;
          else begin
            shreg <= {bit_in, shreg[7:1]};
            idx   <= idx + 1'b1;
            cnt   <= speed_fast ? RELOAD_FAST : RELOAD_SLOW;
            if (idx == 3'd7) st <= RX_STOP;
          end
        RX_STOP: if (cnt != '0) cnt <= cnt - 1'b1;
          else begin
            data_evt  <= 1'b1;
            data_byte <= shreg;
            st        <= RX_IDLE;
          end
        default: st <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/in_port_ctrl.sv
module in_port_ctrl (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  output logic       in_ack,
  output logic       data_req,
  output logic [7:0] data_byte,
  output logic       capture,
  input  logic       data_done,
  input  logic       remote_ack
);
  import lpa_pkg::*;
  in_state_e st;
  logic      valid_q;

  assign capture  = (st == IN_IDLE) && in_valid && !valid_q;
  assign data_req = (st == IN_SEND);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= IN_IDLE; valid_q <= 1'b0; in_ack <= 1'b0; data_byte <= '0;
    end else begin
      valid_q <= in_valid;
      case (st)
        IN_IDLE: if (capture) begin
          data_byte <= in_data;
          st        <= IN_SEND;
        end
        IN_SEND: if (data_done) st <= IN_WAIT;
        IN_WAIT: if (remote_ack) begin
          in_ack <= 1'b1;
          st     <= IN_HOLD;
        end
        IN_HOLD: if (!in_valid) begin
          in_ack <= 1'b0;
          st     <= IN_IDLE;
        end
        default: st <= IN_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/out_port_ctrl.sv
module out_port_ctrl (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_data_evt,
  input  logic [7:0] rx_byte,
  output logic [7:0] out_data,
  output logic       out_valid,
  input  logic       out_ack,
  output logic       ack_req,
  input  logic       ack_done
);
  import lpa_pkg::*;
  out_state_e st;

  assign ack_req = (st == OUT_ACK);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= OUT_IDLE; out_valid <= 1'b0; out_data <= '0;
    end else begin
      case (st)
        OUT_IDLE: if (rx_data_evt) begin
          out_data  <= rx_byte;
          out_valid <= 1'b1;
          st        <= OUT_SHOW;
        end
        OUT_SHOW: if (out_ack) begin
          out_valid <= 1'b0;
          st        <= OUT_DRAIN;
        end
        OUT_DRAIN: if (!out_ack) st <= OUT_ACK;
        OUT_ACK:   if (ack_done) st <= OUT_IDLE;
        default:   st <= OUT_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/link_port_adaptor.sv
module link_port_adaptor #(
  parameter int BIT_SLOW = 8,
  parameter int BIT_FAST = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       speed_fast,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  output logic       in_ack,
  output logic [7:0] out_data,
  output logic       out_valid,
  input  logic       out_ack,
  input  logic       link_in,
  output logic       link_out
);
  // Named internal events, also used by the bound checker.
  logic       in_capture, data_req, data_done;
  logic       ack_req, ack_done, ack_start;
  logic       rx_ack_evt, rx_data_evt;
  logic [7:0] tx_byte, rx_byte;

  in_port_ctrl u_in (
    .clk, .rst, .in_data, .in_valid, .in_ack,
    .data_req, .data_byte(tx_byte), .capture(in_capture),
    .data_done, .remote_ack(rx_ack_evt)
  );

  out_port_ctrl u_out (
    .clk, .rst, .rx_data_evt, .rx_byte, .out_data, .out_valid,
    .out_ack, .ack_req, .ack_done
  );

  link_tx #(.BIT_SLOW(BIT_SLOW), .BIT_FAST(BIT_FAST)) u_tx (
    .clk, .rst, .speed_fast, .data_req, .data_byte(tx_byte), .ack_req,
    .data_done, .ack_done, .ack_start, .line(link_out)
  );

  link_rx #(.BIT_SLOW(BIT_SLOW), .BIT_FAST(BIT_FAST)) u_rx (
    .clk, .rst, .speed_fast, .line(link_in),
    .ack_evt(rx_ack_evt), .data_evt(rx_data_evt), .data_byte(rx_byte)
  );
endmodule

// File: rtl/link_port_adaptor_chk.sv
module link_port_adaptor_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_ack,
  input logic [7:0] out_data,
  input logic       out_valid,
  input logic       out_ack,
  input logic       link_out,
  input logic       in_capture,
  input logic       rx_ack_evt,
  input logic       ack_start
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!in_ack && !out_valid && !link_out));

  a_r3_ack_after_remote: assert property (@(posedge clk) disable iff (rst)
    $rose(in_ack) |-> $past(rx_ack_evt));

  a_r4_ack_follows_valid: assert property (@(posedge clk) disable iff (rst)
    $fell(in_ack) |-> !$past(in_valid));

  a_r5_capture_on_rise: assert property (@(posedge clk) disable iff (rst)
    in_capture |-> (in_valid && !in_ack));

  a_r6_hold_data: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(out_valid)) |-> $stable(out_data));

  a_r7_valid_drop: assert property (@(posedge clk) disable iff (rst)
    $fell(out_valid) |-> $past(out_ack));

  a_r7_ack_gated: assert property (@(posedge clk) disable iff (rst)
    ack_start |-> (!out_ack && !out_valid));
endmodule

bind link_port_adaptor link_port_adaptor_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ack(in_ack),
  .out_data(out_data), .out_valid(out_valid), .out_ack(out_ack),
  .link_out(link_out), .in_capture(in_capture),
  .rx_ack_evt(rx_ack_evt), .ack_start(ack_start)
);

// File: tb/sim_link_port_adaptor.sv
`timescale 1ns/1ps
module sim_link_port_adaptor;
  localparam int BS = 8;
  localparam int BF = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic speed_fast = 1'b0;
  logic [7:0] in_data = '0;
  logic in_valid = 1'b0;
  logic out_ack = 1'b0;
  logic drv_link = 1'b0;
  logic lb = 1'b0;
  logic in_ack, out_valid, link_out, link_in;
  logic [7:0] out_data;
  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int per;

  always #5 clk = ~clk;
  assign link_in = lb ? link_out : drv_link;

  link_port_adaptor #(.BIT_SLOW(BS), .BIT_FAST(BF)) u0 (
    .clk, .rst, .speed_fast, .in_data, .in_valid, .in_ack,
    .out_data, .out_valid, .out_ack, .link_in, .link_out
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit cond(input int sel);
    case (sel)
      0: return out_valid;
      1: return !out_valid;
      2: return in_ack;
      default: return link_out;
    endcase
  endfunction

  task automatic wait_until(input int sel, input int limit, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < limit; i++) begin
      if (cond(sel)) begin ok = 1'b1; return; end
      @(negedge clk);
    end
  endtask

  task automatic do_reset(input bit fast);
    speed_fast = fast;
    per = fast ? BF : BS;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    // R1: outputs quiet while reset is asserted
    chk(!in_ack && !out_valid && !link_out, "R1", {in_ack, out_valid, link_out}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!in_ack && !out_valid && !link_out, "R1", {in_ack, out_valid, link_out}, 0);
  endtask

  task automatic drive_frame(input logic [10:0] fr, input int n);
    for (int k = 0; k < n; k++) begin
      drv_link = fr[k];
      repeat (per) @(negedge clk);
    end
    drv_link = 1'b0;
  endtask

  // R2/R8: sample link_out at bit centres; R3/R4/R5 around it.
  task automatic send_test(input logic [7:0] b);
    bit ok;
    logic [10:0] exp_fr;
    exp_fr = {1'b0, b, 2'b11};
    lb = 1'b0;
    in_data = b; in_valid = 1'b1;
    @(negedge clk);
    in_data = ~b;  // R5: later bus changes must not matter
    wait_until(3, 20, ok);
    chk(ok, "R2", ok, 1);
    for (int k = 0; k < 11; k++) begin
      repeat ((k == 0) ? per / 2 : per) @(negedge clk);
      chk(link_out == exp_fr[k], (k >= 2 && k <= 9) ? "R5" : "R8", link_out, exp_fr[k]);
    end
    repeat (per) @(negedge clk);
    chk(!link_out, "R2", link_out, 0);
    repeat (60) @(negedge clk);
    chk(!in_ack, "R3", in_ack, 0);
    drive_frame(11'b01, 2);
    wait_until(2, 40, ok);
    chk(ok, "R3", in_ack, 1);
    in_valid = 1'b0;
    @(negedge clk);
    chk(!in_ack, "R4", in_ack, 0);
  endtask

  // R6/R7: receive a frame from the bench, check the ack gating.
  task automatic recv_test(input logic [7:0] b);
    bit ok, quiet;
    lb = 1'b0;
    drive_frame({1'b0, b, 2'b11}, 11);
    wait_until(0, 20, ok);
    chk(ok && out_data == b, "R6", out_data, b);
    quiet = 1'b1;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (link_out) quiet = 1'b0; end
    chk(quiet && out_data == b, "R7", link_out, 0);
    out_ack = 1'b1;
    wait_until(1, 5, ok);
    chk(ok, "R7", out_valid, 0);
    quiet = 1'b1;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (link_out) quiet = 1'b0; end
    chk(quiet, "R7", link_out, 0);
    out_ack = 1'b0;
    wait_until(3, 10, ok);
    chk(ok, "R7", ok, 1);
    repeat (per / 2) @(negedge clk);
    chk(link_out == 1'b1, "R2", link_out, 1);
    repeat (per) @(negedge clk);
    chk(link_out == 1'b0, "R2", link_out, 0);
    repeat (2 * per) @(negedge clk);
  endtask

  // End-to-end loopback: byte travels out, back in, ack travels back.
  task automatic loop_byte(input logic [7:0] b);
    bit ok;
    lb = 1'b1;
    in_data = b; in_valid = 1'b1;
    @(negedge clk);
    in_data = b ^ 8'h5A;
    wait_until(0, 20 * per, ok);
    chk(ok && out_data == b, "R6", out_data, b);
    chk(!in_ack, "R3", in_ack, 0);
    repeat (3) @(negedge clk);
    chk(out_data == b && out_valid, "R6", out_data, b);
    out_ack = 1'b1;
    wait_until(1, 5, ok);
    chk(ok, "R7", out_valid, 0);
    repeat (4 * per) @(negedge clk);
    chk(!in_ack && !link_out, "R7", {in_ack, link_out}, 0);
    out_ack = 1'b0;
    wait_until(2, 8 * per, ok);
    chk(ok, "R3", in_ack, 1);
    in_valid = 1'b0;
    @(negedge clk);
    chk(!in_ack, "R4", in_ack, 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    @(negedge clk);
    do_reset(1'b0);
    send_test(8'hA4);
    recv_test(8'h3C);
    for (int i = 0; i < 8; i++) loop_byte(8'(i * 37 + 1));
    do_reset(1'b1);
    send_test(8'h5B);
    recv_test(8'hC1);
    for (int i = 0; i < 256; i++) loop_byte(8'(i));
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule